// File: doc/BRIEF.md
# Eight-bit Accumulator CPU Opcode Decoder

This block turns a single opcode byte of a small 8-bit accumulator processor into the control fields that the rest of the datapath acts on. It is purely combinational. The byte goes in and, in the same cycle, the block reports what kind of operation the byte is, which ALU function it needs, whether the carry flag feeds the adder, which register codes it reads and writes, whether an immediate byte or a 16-bit direct address follows, and how many bytes the whole instruction occupies. A fetch unit uses the length to advance its program counter. The execute stage uses the remaining fields.

The decoder covers the no-operation, move-immediate, register ALU, immediate ALU, indirect accumulator load/store through the BC or DE pair, and direct accumulator load/store opcodes. Every other byte is reported as unimplemented. Branch, stack, I/O and flag logic lie outside this block.

Top module: `opdec8`

## Requirements
- R1: Opcode 0x00 decodes as class NOP (0) with length 1, all flags clear and all register and function fields zero.
- R2: Opcodes with bits 7:6 = 00 and bits 2:0 = 110 decode as class MOVE_IMM (1). The destination register code equals opcode bits 5:3, the immediate flag is set and the length is 2.
- R3: Opcodes 0x80 to 0xBF decode as class ALU_REG (2) with length 1. The ALU function equals opcode bits 5:3 (0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare). The source register equals opcode bits 2:0 and the destination register is 7. Register codes are 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory at HL and 7=A.
- R4: The carry select output is 1, meaning the current carry flag is used, only for add with carry (function 1) and subtract with borrow (function 3) in the ALU classes. It is 0, meaning a carry-in of zero, for every other opcode.
- R5: Opcodes 0xC6, 0xCE, 0xD6, 0xDE, 0xE6, 0xEE, 0xF6 and 0xFE decode as class ALU_IMM (3). The ALU function equals opcode bits 5:3, the destination is 7, the immediate flag is set and the length is 2.
- R6: 0x02 and 0x12 decode as class STORE_IND (5) with source 7 and destination 0 (BC) or 2 (DE). 0x0A and 0x1A decode as class LOAD_IND (4) with source 0 (BC) or 2 (DE) and destination 7. All four have length 1.
- R7: 0x32 decodes as class STORE_DIR (7) with source 7, and 0x3A decodes as class LOAD_DIR (6) with destination 7. Both set the direct-address flag and have length 3.
- R8: Any opcode not named in R1 to R7 sets the unimplemented flag and decodes as class 0, length 1, with every other field zero.
- R9: The immediate flag is set exactly when the length is 2, and the direct-address flag is set exactly when the length is 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 8 | Opcode byte to decode |
| op_class_o | output | 3 | Operation class code |
| alu_fn_o | output | 3 | ALU function code |
| use_carry_o | output | 1 | 1: carry-in from carry flag, 0: carry-in zero |
| src_reg_o | output | 3 | Source register code |
| dst_reg_o | output | 3 | Destination register code |
| imm_o | output | 1 | One immediate byte follows |
| direct_o | output | 1 | A 16-bit direct address follows |
| len_o | output | 2 | Instruction length in bytes |
| unimpl_o | output | 1 | Opcode not supported |

## Verification
The checker watches the fields on every cycle for their consistency with each other and with the opcode. It checks that the operand flags agree with the length, that the carry select appears only on the two carrying ALU functions, that register-range opcodes always yield the register ALU class with their low bits as source, and that an unimplemented opcode leaves every other field clear. Only the bench's scenarios can show that each listed opcode receives its exact class, function, register codes and length. They can also show that the sparse single opcodes are not confused with the gaps around them. For this reason the bench drives all 256 byte values against a model written from the requirements.

// File: rtl/opdec8.sv
module opdec8 (
  input  logic [7:0] opcode_i,
  output logic [2:0] op_class_o,
  output logic [2:0] alu_fn_o,
  output logic       use_carry_o,
  output logic [2:0] src_reg_o,
  output logic [2:0] dst_reg_o,
  output logic       imm_o,
  output logic       direct_o,
  output logic [1:0] len_o,
  output logic       unimpl_o
);
  localparam logic [2:0] CLS_NOP       = 3'd0;
  localparam logic [2:0] CLS_MOVE_IMM  = 3'd1;
  localparam logic [2:0] CLS_ALU_REG   = 3'd2;
  localparam logic [2:0] CLS_ALU_IMM   = 3'd3;
  localparam logic [2:0] CLS_LOAD_IND  = 3'd4;
  localparam logic [2:0] CLS_STORE_IND = 3'd5;
  localparam logic [2:0] CLS_LOAD_DIR  = 3'd6;
  localparam logic [2:0] CLS_STORE_DIR = 3'd7;
  localparam logic [2:0] REG_ACC       = 3'd7;
  localparam logic [2:0] PAIR_BC       = 3'd0;
  localparam logic [2:0] PAIR_DE       = 3'd2;

  logic [1:0] grp;
  logic [2:0] mid, low;
  logic       is_alu;

  assign grp = opcode_i[7:6];
  assign mid = opcode_i[5:3];
  assign low = opcode_i[2:0];

  always_comb begin
    op_class_o = CLS_NOP;
    alu_fn_o   = 3'd0;
    src_reg_o  = 3'd0;
    dst_reg_o  = 3'd0;
    imm_o      = 1'b0;
    direct_o   = 1'b0;
    len_o      = 2'd1;
    unimpl_o   = 1'b0;
    if (opcode_i == 8'h00) begin
      op_class_o = CLS_NOP;
    end else if (grp == 2'b00 && low == 3'b110) begin
      op_class_o = CLS_MOVE_IMM;
      dst_reg_o  = mid;
      imm_o      = 1'b1;
      len_o      = 2'd2;
    end else if (grp == 2'b10) begin
      op_class_o = CLS_ALU_REG;
      alu_fn_o   = mid;
      src_reg_o  = low;
      dst_reg_o  = REG_ACC;
    end else if (grp == 2'b11 && low == 3'b110) begin
      op_class_o = CLS_ALU_IMM;
      alu_fn_o   = mid;
      dst_reg_o  = REG_ACC;
      imm_o      = 1'b1;
      len_o      = 2'd2;
    end else begin
      case (opcode_i)
        8'h02: begin op_class_o = CLS_STORE_IND; src_reg_o = REG_ACC; dst_reg_o = PAIR_BC; end
        8'h12: begin op_class_o = CLS_STORE_IND; src_reg_o = REG_ACC; dst_reg_o = PAIR_DE; end
        8'h0A: begin op_class_o = CLS_LOAD_IND;  src_reg_o = PAIR_BC; dst_reg_o = REG_ACC; end
        8'h1A: begin op_class_o = CLS_LOAD_IND;  src_reg_o = PAIR_DE; dst_reg_o = REG_ACC; end
        8'h32: begin
          op_class_o = CLS_STORE_DIR;
          src_reg_o  = REG_ACC;
          direct_o   = 1'b1;
          len_o      = 2'd3;
        end
        8'h3A: begin
          op_class_o = CLS_LOAD_DIR;
          dst_reg_o  = REG_ACC;
          direct_o   = 1'b1;
          len_o      = 2'd3;
        end
        default: unimpl_o = 1'b1;
      endcase
    end
  end

  assign is_alu      = (op_class_o == CLS_ALU_REG) || (op_class_o == CLS_ALU_IMM);
  assign use_carry_o = is_alu && (alu_fn_o == 3'd1 || alu_fn_o == 3'd3);
endmodule

module opdec8_chk (
  input logic [7:0] opcode_i,
  input logic [2:0] op_class_o,
  input logic [2:0] alu_fn_o,
  input logic       use_carry_o,
  input logic [2:0] src_reg_o,
  input logic [2:0] dst_reg_o,
  input logic       imm_o,
  input logic       direct_o,
  input logic [1:0] len_o,
  input logic       unimpl_o
);
  always_comb begin
    p_imm_len_r9: assert (imm_o == (len_o == 2'd2))
      else $error("imm flag and length disagree");
    p_dir_len_r9: assert (direct_o == (len_o == 2'd3))
      else $error("direct flag and length disagree");
    p_dir_class_r7: assert (!direct_o || op_class_o[2:1] == 2'b11)
      else $error("direct flag outside direct classes");
    p_carry_fn_r4: assert (!use_carry_o ||
                           ((op_class_o == 3'd2 || op_class_o == 3'd3) && alu_fn_o[0] && !alu_fn_o[2]))
      else $error("carry select on wrong function");
    p_reg_alu_r3: assert (opcode_i[7:6] != 2'b10 ||
                          (op_class_o == 3'd2 && src_reg_o == opcode_i[2:0] && len_o == 2'd1))
      else $error("register ALU opcode misdecoded");
    p_movi_op_r2: assert (op_class_o != 3'd1 ||
                          (opcode_i[7:6] == 2'b00 && opcode_i[2:0] == 3'b110 && dst_reg_o == opcode_i[5:3]))
      else $error("move-immediate class from wrong opcode");
    p_unimpl_clear_r8: assert (!unimpl_o ||
                               (op_class_o == 3'd0 && alu_fn_o == 3'd0 && !use_carry_o &&
                                src_reg_o == 3'd0 && dst_reg_o == 3'd0 && !imm_o && !direct_o && len_o == 2'd1))
      else $error("unimplemented opcode with live fields");
  end
endmodule

bind opdec8 opdec8_chk chk_i (.*);

// File: tb/opdec8_tb_top.sv
module opdec8_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] opcode_i = 8'h00;
  logic [2:0] op_class_o, alu_fn_o, src_reg_o, dst_reg_o;
  logic       use_carry_o, imm_o, direct_o, unimpl_o;
  logic [1:0] len_o;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  opdec8 dut_i (
    .opcode_i(opcode_i), .op_class_o(op_class_o), .alu_fn_o(alu_fn_o),
    .use_carry_o(use_carry_o), .src_reg_o(src_reg_o), .dst_reg_o(dst_reg_o),
    .imm_o(imm_o), .direct_o(direct_o), .len_o(len_o), .unimpl_o(unimpl_o)
  );

  task automatic model(input logic [7:0] op, output logic [19:0] e, output string req);
    logic [2:0] c, f, s, d;
    logic ca, im, di, un;
    logic [1:0] l;
    logic [7:0] t;
    c = 0; f = 0; s = 0; d = 0; ca = 0; im = 0; di = 0; un = 0; l = 1;
    if (op == 8'h00) req = "R1";
    else if (op inside {8'h06, 8'h0E, 8'h16, 8'h1E, 8'h26, 8'h2E, 8'h36, 8'h3E}) begin
      req = "R2"; c = 1; t = (op - 8'h06) / 8; d = t[2:0]; im = 1; l = 2;
    end else if (op >= 8'h80 && op <= 8'hBF) begin
      req = "R3"; c = 2; t = (op - 8'h80) / 8; f = t[2:0]; t = op % 8; s = t[2:0]; d = 7;
      ca = (f == 1 || f == 3);
    end else if (op inside {8'hC6, 8'hCE, 8'hD6, 8'hDE, 8'hE6, 8'hEE, 8'hF6, 8'hFE}) begin
      req = "R5"; c = 3; t = (op - 8'hC6) / 8; f = t[2:0]; d = 7; im = 1; l = 2;
      ca = (op == 8'hCE || op == 8'hDE);
    end else if (op == 8'h02) begin req = "R6"; c = 5; s = 7; d = 0; end
    else if (op == 8'h12) begin req = "R6"; c = 5; s = 7; d = 2; end
    else if (op == 8'h0A) begin req = "R6"; c = 4; s = 0; d = 7; end
    else if (op == 8'h1A) begin req = "R6"; c = 4; s = 2; d = 7; end
    else if (op == 8'h32) begin req = "R7"; c = 7; s = 7; di = 1; l = 3; end
    else if (op == 8'h3A) begin req = "R7"; c = 6; d = 7; di = 1; l = 3; end
    else begin req = "R8"; un = 1; end
    e = {c, f, ca, s, d, im, di, l, un};
  endtask

  task automatic apply(input logic [7:0] op, input string tag);
    logic [19:0] exp_v, act_v;
    string req;
    @(negedge clk);
    opcode_i = op;
    #1;
    model(op, exp_v, req);
    act_v = {op_class_o, alu_fn_o, use_carry_o, src_reg_o, dst_reg_o, imm_o, direct_o, len_o, unimpl_o};
    n_vec++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s/%s op=%02h actual=%05h expected=%05h", req, tag, op, act_v, exp_v);
    end
    if ((imm_o !== (len_o == 2'd2)) || (direct_o !== (len_o == 2'd3))) begin
      n_bad++;
      $display("FAIL R9 op=%02h actual imm=%0b dir=%0b len=%0d expected flags matching length", op, imm_o, direct_o, len_o);
    end
  endtask

  task automatic t_reset;
    opcode_i = 8'h00;
    #1;
    n_vec++;
    if (op_class_o !== 3'd0 || len_o !== 2'd1 || unimpl_o !== 1'b0 || imm_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: actual class=%0d len=%0d unimpl=%0b expected 0 1 0", op_class_o, len_o, unimpl_o);
    end
  endtask

  task automatic t_nop;            apply(8'h00, "nop"); endtask
  task automatic t_move_imm;       for (int i = 0; i < 8; i++) apply(8'(8'h06 + 8 * i), "mvi"); endtask
  task automatic t_alu_reg;        for (int i = 8'h80; i <= 8'hBF; i++) apply(8'(i), "alu_reg"); endtask
  task automatic t_carry;
    apply(8'h88, "R4 adc"); apply(8'h9F, "R4 sbb"); apply(8'h80, "R4 add");
    apply(8'hB8, "R4 cmp"); apply(8'hCE, "R4 aci"); apply(8'hD6, "R4 sui");
  endtask
  task automatic t_alu_imm;        for (int i = 0; i < 8; i++) apply(8'(8'hC6 + 8 * i), "alu_imm"); endtask
  task automatic t_indirect;
    apply(8'h02, "stax bc"); apply(8'h0A, "ldax bc"); apply(8'h12, "stax de"); apply(8'h1A, "ldax de");
  endtask
  task automatic t_direct;         apply(8'h32, "sta"); apply(8'h3A, "lda"); endtask
  task automatic t_neighbours;
    apply(8'h22, "R8 near"); apply(8'h2A, "R8 near"); apply(8'h01, "R8 near");
    apply(8'h7F, "R8 mov"); apply(8'hC0, "R8 near"); apply(8'hC7, "R8 near"); apply(8'hFF, "R8 near");
  endtask
  task automatic t_sweep;          for (int i = 0; i < 256; i++) apply(8'(i), "sweep"); endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_nop;
    t_move_imm;
    t_alu_reg;
    t_carry;
    t_alu_imm;
    t_indirect;
    t_direct;
    t_neighbours;
    t_sweep;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule